// File: doc/BRIEF.md
# Ganged Slice Warp Controller

This block steers the front end of a core built from eight narrow execution slices, each four lanes wide and each with its own program counter and fetch/decode port. Slices whose program counters are equal are fused into one gang. A gang is served by a single fetch, issued by its leader, which is its lowest-numbered slice. The front ends of the other members stay idle. When the members of a gang resolve a branch differently, the gang splits into subgroups, one per distinct next PC. Subgroups that arrive at the same PC fuse again on the following cycle.

Each slice has a small private instruction buffer, seen here only as a per-slice hit input. A gang whose leader hits advances at once. A gang whose leader misses competes for the one shared upper-level fetch port. Round-robin arbitration picks one requester, and that request is presented on the next cycle. It stays presented, with its gang frozen, until the acknowledge arrives, and the gang then advances. Every gang advance uses the branch outcome of each member slice: a taken flag and a target.

Top module: `gsw_ctrl`

## Requirements
- R1: After reset, every slice PC is 0, all eight slices form one gang (every gang_map row is 8'hFF), leader is 8'h01 and l1_req is 0.
- R2: Bit j of gang_map row i (bit i*8+j) is 1 exactly when slices i and j have equal PCs and either both or neither belong to the gang waiting on the shared port.
- R3: leader bit i is 1 exactly when slice i is the lowest-numbered member of its gang.
- R4: fetch_en is 1 only at a gang leader. It is 1 when that gang advances this cycle: the leader's l0_hit is 1 and the gang is not waiting, or the gang is waiting and l1_ack is 1.
- R5: When its gang advances, slice i loads br_target slice i if br_taken[i] is 1, and otherwise loads PC+4. A slice that does not advance keeps its PC.
- R6: A gang whose members resolve different next PCs splits into one gang per distinct PC.
- R7: Gangs whose PCs become equal merge into one gang with one leader on the next cycle.
- R8: When no request is outstanding, the lowest-indexed missing leader at or after the round-robin pointer (wrapping) wins. The pointer then moves to winner+1. From the next cycle, l1_req is 1 and l1_slice and l1_pc show the winner and its PC until the cycle of l1_ack. l1_req is 0 after that cycle.
- R9: A gang waiting on the shared port holds its PCs regardless of l0_hit. l1_ack has no effect while no request is outstanding.
- R10: The state with eight single-slice gangs is legal, and the slices re-gang from it when their PCs converge.
- R11: l0_hit of a slice that is not a leader has no effect on any fetch or PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l0_hit | input | 8 | Per-slice private buffer hit |
| br_taken | input | 8 | Per-slice branch taken flag for the instruction advancing |
| br_target | input | 128 | Per-slice branch target, slice i at bits [16i+15:16i] |
| l1_ack | input | 1 | Acknowledge of the outstanding shared-port request |
| fetch_en | output | 8 | Per-slice fetch enable (leaders only) |
| slice_pc | output | 128 | Per-slice program counter, slice i at bits [16i+15:16i] |
| gang_map | output | 64 | Gang membership bitmap, row i at bits [8i+7:8i] |
| leader | output | 8 | Gang leader flags |
| l1_req | output | 1 | Shared-port request outstanding |
| l1_slice | output | 3 | Leader slice of the outstanding request |
| l1_pc | output | 16 | PC of the outstanding request |

## Verification
The hardest states to reach are the fully split state and the re-gang from it. A waiting gang that shares a PC with a free-running subgroup that has not yet been merged is also hard to reach. Directed steps send every slice to a distinct target, then send all of them to one target. They also make a gang's leader miss while the other members hit, and drop a split subgroup onto its sibling's next PC. A long random phase then draws targets from a pool of three addresses. Random hits and acknowledges keep requests outstanding while other gangs collide on the waiting gang's PC. A periodic forced full split is mixed in.

// File: rtl/gsw_pkg.sv
package gsw_pkg;
  localparam int GSW_NSLICE = 8;
  localparam int GSW_PCW    = 16;
  localparam int GSW_STEP   = 4;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_L0   = 2'd1,
    SRC_L1   = 2'd2
  } src_e;
endpackage

// File: rtl/gsw_group.sv
module gsw_group #(
  parameter int NSLICE = 8,
  parameter int PCW    = 16
) (
  input  logic [NSLICE*PCW-1:0]    pc_flat,
  input  logic [NSLICE-1:0]        frozen,
  output logic [NSLICE*NSLICE-1:0] gang_map,
  output logic [NSLICE-1:0]        leader
);
  always_comb begin
    gang_map = '0;
    for (int i = 0; i < NSLICE; i++) begin
      for (int j = 0; j < NSLICE; j++) begin
        gang_map[i*NSLICE+j] = (pc_flat[i*PCW +: PCW] == pc_flat[j*PCW +: PCW]) &&
                               (frozen[i] == frozen[j]);
      end
    end
  end

  always_comb begin
    leader = '1;
    for (int i = 0; i < NSLICE; i++) begin
      for (int j = 0; j < i; j++) begin
        if (gang_map[i*NSLICE+j]) leader[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/gsw_rr_arb.sv
module gsw_rr_arb #(
  parameter int NSLICE = 8,
  localparam int IDXW  = $clog2(NSLICE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [NSLICE-1:0] req,
  output logic              gnt_vld,
  output logic [IDXW-1:0]   gnt_idx
);
  logic [IDXW-1:0] ptr_q, ptr_d;

  always_comb begin
    int c;
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int k = NSLICE-1; k >= 0; k--) begin
      c = (int'(ptr_q) + k) % NSLICE;
      if (en && req[c]) begin
        gnt_vld = 1'b1;
        gnt_idx = IDXW'(c);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (gnt_vld) ptr_d = IDXW'((int'(gnt_idx) + 1) % NSLICE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (gnt_vld) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/gsw_pc_file.sv
module gsw_pc_file #(
  parameter int NSLICE = 8,
  parameter int PCW    = 16,
  parameter int STEP   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSLICE-1:0]     adv,
  input  logic [NSLICE-1:0]     br_taken,
  input  logic [NSLICE*PCW-1:0] br_target,
  output logic [NSLICE*PCW-1:0] pc_flat
);
  localparam logic [PCW-1:0] STEP_V = PCW'(STEP);

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    logic [PCW-1:0] pc_q, pc_d;

    always_comb begin
      if (br_taken[i]) pc_d = br_target[i*PCW +: PCW];
      else             pc_d = pc_q + STEP_V;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pc_q <= '0;
      else if (adv[i]) pc_q <= pc_d;
    end

    assign pc_flat[i*PCW +: PCW] = pc_q;
  end
endmodule

// File: rtl/gsw_ctrl.sv
module gsw_ctrl
  import gsw_pkg::*;
#(
  parameter int NSLICE = GSW_NSLICE,
  parameter int PCW    = GSW_PCW,
  parameter int STEP   = GSW_STEP,
  localparam int IDXW  = $clog2(NSLICE)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSLICE-1:0]        l0_hit,
  input  logic [NSLICE-1:0]        br_taken,
  input  logic [NSLICE*PCW-1:0]    br_target,
  input  logic                     l1_ack,
  output logic [NSLICE-1:0]        fetch_en,
  output logic [NSLICE*PCW-1:0]    slice_pc,
  output logic [NSLICE*NSLICE-1:0] gang_map,
  output logic [NSLICE-1:0]        leader,
  output logic                     l1_req,
  output logic [IDXW-1:0]          l1_slice,
  output logic [PCW-1:0]           l1_pc
);
  logic [NSLICE-1:0]        frozen, lead, adv, miss_req, lead_hit;
  logic [NSLICE*NSLICE-1:0] gmap;
  logic [NSLICE*PCW-1:0]    pcs;
  src_e                     src [NSLICE];

  logic              pend_q, pend_d;
  logic [NSLICE-1:0] pmask_q, pmask_d;
  logic [IDXW-1:0]   pl_q, pl_d;
  logic              gnt_vld;
  logic [IDXW-1:0]   gnt_idx;

  assign frozen = pend_q ? pmask_q : '0;

  gsw_group #(.NSLICE(NSLICE), .PCW(PCW)) u_grp (
    .pc_flat (pcs),
    .frozen  (frozen),
    .gang_map(gmap),
    .leader  (lead)
  );

  // each slice follows the buffer hit of its own gang's leader
  always_comb begin
    for (int i = 0; i < NSLICE; i++) begin
      lead_hit[i] = 1'b0;
      for (int j = NSLICE-1; j >= 0; j--) begin
        if (gmap[i*NSLICE+j]) lead_hit[i] = l0_hit[j];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NSLICE; i++) begin
      if (frozen[i])        src[i] = l1_ack ? SRC_L1 : SRC_NONE;
      else if (lead_hit[i]) src[i] = SRC_L0;
      else                  src[i] = SRC_NONE;
      adv[i]      = (src[i] != SRC_NONE);
      miss_req[i] = lead[i] && !frozen[i] && !l0_hit[i];
    end
  end

  gsw_rr_arb #(.NSLICE(NSLICE)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (!pend_q),
    .req    (miss_req),
    .gnt_vld(gnt_vld),
    .gnt_idx(gnt_idx)
  );

  gsw_pc_file #(.NSLICE(NSLICE), .PCW(PCW), .STEP(STEP)) u_pcs (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .br_taken (br_taken),
    .br_target(br_target),
    .pc_flat  (pcs)
  );

  always_comb begin
    pend_d  = pend_q;
    pmask_d = pmask_q;
    pl_d    = pl_q;
    if (pend_q && l1_ack) begin
      pend_d = 1'b0;
    end else if (gnt_vld) begin
      pend_d  = 1'b1;
      pmask_d = gmap[int'(gnt_idx)*NSLICE +: NSLICE];
      pl_d    = gnt_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pmask_q <= '0;
      pl_q    <= '0;
    end else begin
      pend_q <= pend_d;
      if (gnt_vld) begin
        pmask_q <= pmask_d;
        pl_q    <= pl_d;
      end
    end
  end

  assign fetch_en = lead & adv;
  assign slice_pc = pcs;
  assign gang_map = gmap;
  assign leader   = lead;
  assign l1_req   = pend_q;
  assign l1_slice = pl_q;
  assign l1_pc    = pcs[int'(pl_q)*PCW +: PCW];
endmodule

// File: rtl/gsw_chk.sv
module gsw_chk #(
  parameter int NSLICE = 8,
  parameter int PCW    = 16,
  localparam int IDXW  = $clog2(NSLICE)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     l1_ack,
  input logic [NSLICE-1:0]        fetch_en,
  input logic [NSLICE*PCW-1:0]    slice_pc,
  input logic [NSLICE*NSLICE-1:0] gang_map,
  input logic [NSLICE-1:0]        leader,
  input logic                     l1_req,
  input logic [IDXW-1:0]          l1_slice,
  input logic [PCW-1:0]           l1_pc
);
  p_fetch_at_leader_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en & ~leader) == '0);

  p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_req && !l1_ack) |=> (l1_req && $stable(l1_slice) && $stable(l1_pc)));

  p_req_leader_r8: assert property (@(posedge clk) disable iff (!rst_n)
    l1_req |-> leader[l1_slice]);

  for (genvar i = 0; i < NSLICE; i++) begin : g_row
    p_self_member_r2: assert property (@(posedge clk) disable iff (!rst_n)
      gang_map[i*NSLICE+i]);

    p_one_leader_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gang_map[i*NSLICE +: NSLICE] & leader) == 1);

    for (genvar j = 0; j < NSLICE; j++) begin : g_col
      p_member_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gang_map[i*NSLICE+j] |-> (slice_pc[i*PCW +: PCW] == slice_pc[j*PCW +: PCW]));

      if (j > i) begin : g_pair
        p_merged_r7: assert property (@(posedge clk) disable iff (!rst_n)
          (leader[i] && leader[j] && slice_pc[i*PCW +: PCW] == slice_pc[j*PCW +: PCW])
          |-> (l1_req && (int'(l1_slice) == i || int'(l1_slice) == j)));
      end
    end
  end
endmodule

bind gsw_ctrl gsw_chk #(.NSLICE(NSLICE), .PCW(PCW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .l1_ack  (l1_ack),
  .fetch_en(fetch_en),
  .slice_pc(slice_pc),
  .gang_map(gang_map),
  .leader  (leader),
  .l1_req  (l1_req),
  .l1_slice(l1_slice),
  .l1_pc   (l1_pc)
);

// File: tb/gsw_ctrl_bench.sv
module gsw_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   l0_hit, br_taken, fetch_en, leader;
  logic [N*W-1:0] br_target, slice_pc;
  logic           l1_ack, l1_req;
  logic [N*N-1:0] gang_map;
  logic [2:0]     l1_slice;
  logic [W-1:0]   l1_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  gsw_ctrl u_gsw_ctrl (
    .clk(clk), .rst_n(rst_n), .l0_hit(l0_hit), .br_taken(br_taken),
    .br_target(br_target), .l1_ack(l1_ack), .fetch_en(fetch_en),
    .slice_pc(slice_pc), .gang_map(gang_map), .leader(leader),
    .l1_req(l1_req), .l1_slice(l1_slice), .l1_pc(l1_pc)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [W-1:0] m_pc [N];
  bit           m_pend;
  bit [N-1:0]   m_mask;
  int           m_pl, m_ptr;
  logic [W-1:0] d_tgt [N];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // called at a falling edge: drive, compare, advance model across one rising edge
  task automatic step(input logic [N-1:0] hit, input logic [N-1:0] tk, input logic ack);
    bit [N-1:0]   frz, ld, adv, fe;
    bit [N*N-1:0] gm;
    int           li [N];
    logic [W-1:0] npc [N];
    int           g;
    l0_hit = hit; br_taken = tk; l1_ack = ack;
    for (int i = 0; i < N; i++) br_target[i*W +: W] = d_tgt[i];
    #1;
    for (int i = 0; i < N; i++) frz[i] = m_pend && m_mask[i];
    for (int i = 0; i < N; i++) begin
      li[i] = -1;
      for (int j = 0; j < N; j++) begin
        gm[i*N+j] = (m_pc[i] == m_pc[j]) && (frz[i] == frz[j]);
        if (gm[i*N+j] && li[i] < 0) li[i] = j;
      end
      ld[i]  = (li[i] == i);
      adv[i] = frz[i] ? ack : hit[li[i]];
      fe[i]  = ld[i] && adv[i];
    end
    chk("R2 gang_map", 64'(gang_map), 64'(gm));
    chk("R3 leader", 64'(leader), 64'(ld));
    chk("R4 fetch_en", 64'(fetch_en), 64'(fe));
    for (int i = 0; i < N; i++) chk("R5 slice_pc", 64'(slice_pc[i*W +: W]), 64'(m_pc[i]));
    chk("R8 l1_req", 64'(l1_req), 64'(m_pend));
    if (m_pend) begin
      chk("R8 l1_slice", 64'(l1_slice), 64'(m_pl));
      chk("R8 l1_pc", 64'(l1_pc), 64'(m_pc[m_pl]));
    end
    for (int i = 0; i < N; i++)
      npc[i] = adv[i] ? (tk[i] ? d_tgt[i] : m_pc[i] + 16'd4) : m_pc[i];
    @(posedge clk);
    if (m_pend) begin
      if (ack) m_pend = 0;
    end else begin
      g = -1;
      for (int k = N-1; k >= 0; k--) begin
        int c;
        c = (m_ptr + k) % N;
        if (ld[c] && !hit[c]) g = c;
      end
      if (g >= 0) begin
        m_pend = 1; m_pl = g; m_ptr = (g + 1) % N;
        for (int j = 0; j < N; j++) m_mask[j] = gm[g*N+j];
      end
    end
    for (int i = 0; i < N; i++) m_pc[i] = npc[i];
    @(negedge clk);
  endtask

  task automatic set_tgt_all(input logic [W-1:0] t);
    for (int i = 0; i < N; i++) d_tgt[i] = t;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    rst_n = 1'b0; l0_hit = '0; br_taken = '0; br_target = '0; l1_ack = 1'b0;
    for (int i = 0; i < N; i++) begin m_pc[i] = '0; d_tgt[i] = '0; end
    m_pend = 0; m_mask = '0; m_pl = 0; m_ptr = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 gang_map", 64'(gang_map), {64{1'b1}});
    chk("R1 leader", 64'(leader), 64'h01);
    chk("R1 l1_req", 64'(l1_req), 64'h0);
    chk("R1 slice_pc", 64'(slice_pc[63:0]), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    set_tgt_all(16'h0200);
    step(8'hFF, 8'h00, 1'b0);
    chk("R5 step pc", 64'(slice_pc[W-1:0]), 64'h4);
    step(8'hFE, 8'hFF, 1'b0);
    chk("R11 non-leader hits ignored", 64'(slice_pc[7*W +: W]), 64'h4);
    chk("R8 request raised", 64'({l1_req, l1_slice}), 64'h8);
    step(8'hFF, 8'h00, 1'b0);
    chk("R9 waiting gang holds", 64'(slice_pc[3*W +: W]), 64'h4);
    for (int i = 0; i < N; i++) d_tgt[i] = (i >= 4) ? 16'h0080 : 16'h0000;
    step(8'h00, 8'hF0, 1'b1);
    chk("R6 split", 64'(leader), 64'h11);
    for (int i = 0; i < N; i++) d_tgt[i] = 16'h0100 + 16'(i*16);
    step(8'hFF, 8'hFF, 1'b0);
    chk("R10 full split", 64'(leader), 64'hFF);
    set_tgt_all(16'h0040);
    step(8'hFF, 8'hFF, 1'b1);
    chk("R9 stray ack ignored", 64'(l1_req), 64'h0);
    chk("R10 re-gang", 64'(leader), 64'h01);
    set_tgt_all(16'h0060);
    step(8'hFF, 8'h0F, 1'b0);
    chk("R6 second split", 64'(leader), 64'h11);
    set_tgt_all(16'h0064);
    step(8'h11, 8'hF0, 1'b0);
    chk("R7 merge", 64'(leader), 64'h01);

    for (int n = 0; n < 4000; n++) begin
      logic [N-1:0] h, t;
      if (n % 500 == 250) begin
        for (int i = 0; i < N; i++) d_tgt[i] = 16'h0300 + 16'(i*8);
        h = 8'hFF; t = 8'hFF;
      end else begin
        for (int i = 0; i < N; i++) d_tgt[i] = 16'h0040 * 16'(1 + $urandom % 3);
        h = ~(8'($urandom) & 8'($urandom));
        t = 8'($urandom) & 8'($urandom);
      end
      step(h, t, 1'($urandom));
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule